// File: doc/BRIEF.md
# Message Status Signal Sequencer

This block drives the four active-low message event lines that a bus remote terminal presents to its subsystem. An in-command level marks that a message is being processed. A good-block pulse signals that a receive data block arrived complete and clean. A message-error level flags a data-stage error. A handshake-failure level reports a data transfer request that the subsystem did not acknowledge in time. The inputs are single-cycle events that an upstream protocol decoder has already produced: command accepted, command-word error, data-word error, last data word transferred and end of message. The decoder also supplies the direction and mode-code flags of the command and the data transfer request/acknowledge pair.

The block also captures the subsystem's status inputs at a fixed delay after each accepted command, and marks the capture with a one-cycle strobe. Both this delay and the handshake timeout are counted in clock cycles derived from a clock frequency parameter: 2 µs for the sample and 10 µs for the timeout. All outputs are registered and leave reset high (inactive).

Top module: `msg_status_seq`

## Requirements
- R1: After reset, incmd_n, gbr_n, msg_err_n and hs_fail_n are 1, stat_stb is 0 and stat_q is 0.
- R2: A cmd_valid pulse (without cmd_err) drives incmd_n low after that clock edge; an eom pulse during a message drives incmd_n high after its edge.
- R3: A cmd_err pulse ends the message (incmd_n high after its edge), wins over a simultaneous cmd_valid, never lowers msg_err_n, and causes data_err, last_data, eom and dt_req to be ignored until the next cmd_valid.
- R4: A data_err pulse during a message drives msg_err_n low after its edge.
- R5: For a receive command (is_rx=1) that is not a mode code (is_mode=0), a last_data pulse drives gbr_n low for exactly two clock cycles starting after its edge; a transmit or mode-code message gives no pulse.
- R6: hs_fail_n goes low after HS_CYC consecutive clock edges (HS_CYC = CLK_FREQ_HZ/100000, i.e. 10 µs) at which dt_req=1 and dt_ack=0 during a message; an edge with dt_ack=1 or dt_req=0 restarts the count.
- R7: msg_err_n and hs_fail_n, once low, stay low through end of message and idle until a later cmd_valid without cmd_err, which drives both high after its edge.
- R8: stat_in is captured into stat_q at the SMP_CYC-th clock edge after the cmd_valid edge (SMP_CYC = CLK_FREQ_HZ/500000, i.e. 2 µs), with stat_stb high for that one cycle; a cmd_err before that edge cancels the capture.
- R9: A message in which data_err or a handshake failure occurred, including a data_err in the same cycle as last_data, gives no good-block pulse.
- R10: Outside a message, dt_req held without acknowledge never lowers hs_fail_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Valid command word accepted (pulse) |
| cmd_err | input | 1 | Error in the command word (pulse) |
| is_rx | input | 1 | Command is a receive, valid with cmd_valid |
| is_mode | input | 1 | Command is a mode code, valid with cmd_valid |
| data_err | input | 1 | Error in a data word (pulse) |
| last_data | input | 1 | Last data word transferred to the subsystem (pulse) |
| eom | input | 1 | End of message (pulse) |
| dt_req | input | 1 | Data transfer request to the subsystem (level) |
| dt_ack | input | 1 | Subsystem acknowledge of the request |
| stat_in | input | STAT_W | Subsystem status inputs |
| incmd_n | output | 1 | In-command indicator, active low |
| gbr_n | output | 1 | Good-block pulse, active low |
| msg_err_n | output | 1 | Message-error level, active low |
| hs_fail_n | output | 1 | Handshake-failure level, active low |
| stat_q | output | STAT_W | Captured subsystem status |
| stat_stb | output | 1 | One-cycle strobe when stat_q is updated |

## Verification
The assertions check on every cycle that in-command follows command and command-error events, that a command-word error never raises the message error, and that a data error sets it. They also check that both error levels hold until a clearing command, that a handshake failure only follows a pending request, that the good-block pulse is never shorter than two cycles, and that a cancel suppresses the status strobe. Only the bench scenarios can show the exact pulse length and its absence for transmit, mode-code or errored messages. The same holds for the exact timeout count and its restart on acknowledge, the capture instant of the status sample, and the ignoring of events after a command error.

// File: rtl/mss_pkg.sv
package mss_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } mss_state_e;

    typedef struct packed {
        mss_state_e state;
        logic       rx;
        logic       mode;
        logic       bad;
        logic       incmd_n;
        logic       msg_err_n;
        logic       hs_fail_n;
    } mss_ctl_t;

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/mss_hs_watch.sv
module mss_hs_watch #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic req,
    input  logic ack,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             pending;

    always_comb begin
        pending = enable && req && !ack;
        expire  = pending && (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (!pending) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R6: an expiry needs the request pending on the previous edge too (limit above one)
    generate
        if (LIMIT > 1) begin : g_chk
            a_r6_expire_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
                expire |-> $past(pending));
        end
    endgenerate

endmodule

// File: rtl/mss_pulse.sv
module mss_pulse #(
    parameter int WIDTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic out_n
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out_n;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (trig) begin
            p_d.cnt = CNT_W'(WIDTH);
        end else if (p_q.cnt != '0) begin
            p_d.cnt = p_q.cnt - 1'b1;
        end
        p_d.out_n = (p_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{cnt: '0, out_n: 1'b1};
        end else begin
            p_q <= p_d;
        end
    end

    assign out_n = p_q.out_n;

    // R5: a low pulse is never shorter than two cycles
    a_r5_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.out_n) |-> !$past(p_q.out_n, 2));

endmodule

// File: rtl/mss_stat_sample.sv
module mss_stat_sample #(
    parameter int STAT_W = 4,
    parameter int DELAY  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cancel,
    input  logic [STAT_W-1:0] stat_in,
    output logic [STAT_W-1:0] stat_q,
    output logic              stat_stb
);
    localparam int CNT_W = $clog2(DELAY + 1);

    typedef struct packed {
        logic              armed;
        logic [CNT_W-1:0]  cnt;
        logic [STAT_W-1:0] data;
        logic              stb;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        if (cancel) begin
            s_d.armed = 1'b0;
        end else if (start) begin
            s_d.armed = 1'b1;
            s_d.cnt   = CNT_W'(DELAY - 1);
        end else if (s_q.armed) begin
            if (s_q.cnt == '0) begin
                s_d.data  = stat_in;
                s_d.stb   = 1'b1;
                s_d.armed = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_q   = s_q.data;
    assign stat_stb = s_q.stb;

    // R8: a cancel suppresses any capture on the same edge
    a_r8_cancel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !stat_stb);

endmodule

// File: rtl/msg_status_seq.sv
module msg_status_seq
    import mss_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 20_000_000,
    parameter int STAT_W      = 4,
    parameter int GBR_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_err,
    input  logic              is_rx,
    input  logic              is_mode,
    input  logic              data_err,
    input  logic              last_data,
    input  logic              eom,
    input  logic              dt_req,
    input  logic              dt_ack,
    input  logic [STAT_W-1:0] stat_in,
    output logic              incmd_n,
    output logic              gbr_n,
    output logic              msg_err_n,
    output logic              hs_fail_n,
    output logic [STAT_W-1:0] stat_q,
    output logic              stat_stb
);
    localparam int HS_CYC  = at_least_one(CLK_FREQ_HZ / 100_000);
    localparam int SMP_CYC = at_least_one(CLK_FREQ_HZ / 500_000);

    mss_ctl_t ctl_d, ctl_q;
    logic     accept;
    logic     in_msg;
    logic     hs_expire;
    logic     gbr_trig;

    always_comb begin
        accept = cmd_valid && !cmd_err;
        in_msg = (ctl_q.state == ST_ACTIVE) && !cmd_err && !cmd_valid;
        ctl_d  = ctl_q;
        if (cmd_err) begin
            ctl_d.state   = ST_IDLE;
            ctl_d.incmd_n = 1'b1;
        end else if (cmd_valid) begin
            ctl_d.state     = ST_ACTIVE;
            ctl_d.incmd_n   = 1'b0;
            ctl_d.rx        = is_rx;
            ctl_d.mode      = is_mode;
            ctl_d.bad       = 1'b0;
            ctl_d.msg_err_n = 1'b1;
            ctl_d.hs_fail_n = 1'b1;
        end else if (ctl_q.state == ST_ACTIVE) begin
            if (data_err) begin
                ctl_d.msg_err_n = 1'b0;
                ctl_d.bad       = 1'b1;
            end
            if (hs_expire) begin
                ctl_d.hs_fail_n = 1'b0;
                ctl_d.bad       = 1'b1;
            end
            if (eom) begin
                ctl_d.state   = ST_IDLE;
                ctl_d.incmd_n = 1'b1;
            end
        end
        gbr_trig = in_msg && last_data && ctl_q.rx && !ctl_q.mode
                   && !ctl_q.bad && !data_err && !hs_expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, rx: 1'b0, mode: 1'b0, bad: 1'b0,
                       incmd_n: 1'b1, msg_err_n: 1'b1, hs_fail_n: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mss_hs_watch #(.LIMIT(HS_CYC)) u_hs_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (in_msg),
        .req    (dt_req),
        .ack    (dt_ack),
        .expire (hs_expire)
    );

    mss_pulse #(.WIDTH(GBR_CYC)) u_gbr_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (gbr_trig),
        .out_n (gbr_n)
    );

    mss_stat_sample #(.STAT_W(STAT_W), .DELAY(SMP_CYC)) u_stat_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .cancel   (cmd_err),
        .stat_in  (stat_in),
        .stat_q   (stat_q),
        .stat_stb (stat_stb)
    );

    assign incmd_n   = ctl_q.incmd_n;
    assign msg_err_n = ctl_q.msg_err_n;
    assign hs_fail_n = ctl_q.hs_fail_n;

    // R2: an accepted command lowers the in-command line
    a_r2_incmd_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !incmd_n);

    // R3: a command-word error ends the message and never raises a message error
    a_r3_cmderr_ends: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> incmd_n);
    a_r3_cmderr_no_msgerr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && msg_err_n) |=> msg_err_n);

    // R4: a data error inside a message sets the message error
    a_r4_data_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!incmd_n && data_err && !cmd_err && !cmd_valid) |=> !msg_err_n);

    // R7: error levels hold until an accepted command
    a_r7_msgerr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_err_n && !accept) |=> !msg_err_n);
    a_r7_hsfail_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fail_n && !accept) |=> !hs_fail_n);

    // R6: a handshake failure follows a pending, unacknowledged request
    a_r6_fail_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_fail_n) |-> $past(dt_req && !dt_ack));

endmodule

// File: tb/msg_status_seq_bench.sv
module msg_status_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FREQ       = 1_000_000;
    localparam int HS         = FREQ / 100_000;
    localparam int SMP        = FREQ / 500_000;
    localparam int SW         = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 0, cmd_err = 0, is_rx = 0, is_mode = 0;
    logic data_err = 0, last_data = 0, eom = 0, dt_req = 0, dt_ack = 0;
    logic [SW-1:0] stat_in = '0;
    logic incmd_n, gbr_n, msg_err_n, hs_fail_n, stat_stb;
    logic [SW-1:0] stat_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msg_status_seq #(.CLK_FREQ_HZ(FREQ), .STAT_W(SW), .GBR_CYC(2)) u_msg_status_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_err(cmd_err),
        .is_rx(is_rx), .is_mode(is_mode), .data_err(data_err), .last_data(last_data),
        .eom(eom), .dt_req(dt_req), .dt_ack(dt_ack), .stat_in(stat_in),
        .incmd_n(incmd_n), .gbr_n(gbr_n), .msg_err_n(msg_err_n), .hs_fail_n(hs_fail_n),
        .stat_q(stat_q), .stat_stb(stat_stb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulses_off();
        cmd_valid = 0; cmd_err = 0; data_err = 0; last_data = 0; eom = 0;
    endtask

    task automatic start_cmd(input logic rx, input logic md);
        cmd_valid = 1; is_rx = rx; is_mode = md;
        tick();
        pulses_off();
        chk("R2 incmd low after command", incmd_n, 0);
    endtask

    task automatic end_msg();
        eom = 1;
        tick();
        pulses_off();
        chk("R2 incmd high after eom", incmd_n, 1);
    endtask

    function automatic logic want_gbr(input logic rx, input logic md, input logic err);
        return rx && !md && !err;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lows;
        logic err;
        void'($urandom(32'd20240611));
        #(CLK_PERIOD * 2 + 3);
        chk("R1 incmd_n reset", incmd_n, 1);
        chk("R1 gbr_n reset", gbr_n, 1);
        chk("R1 msg_err_n reset", msg_err_n, 1);
        chk("R1 hs_fail_n reset", hs_fail_n, 1);
        chk("R1 stat_stb reset", stat_stb, 0);
        chk("R1 stat_q reset", stat_q, 0);
        rst_n = 1;
        tick();

        // R8 status capture timing, R5 good block on clean receive
        stat_in = 4'h3;
        start_cmd(1, 0);
        for (int i = 1; i < SMP; i++) begin
            chk("R8 no strobe before delay", stat_stb, 0);
            stat_in = 4'h3;
            tick();
        end
        stat_in = 4'hA;
        tick();
        chk("R8 strobe at delay", stat_stb, 1);
        chk("R8 captured value", stat_q, 4'hA);
        stat_in = 4'h5;
        last_data = 1;
        tick();
        pulses_off();
        chk("R8 strobe one cycle", stat_stb, 0);
        chk("R5 gbr low cycle 1", gbr_n, 0);
        tick();
        chk("R5 gbr low cycle 2", gbr_n, 0);
        tick();
        chk("R5 gbr high after two", gbr_n, 1);
        end_msg();
        chk("R4 no error on clean message", msg_err_n, 1);

        // R5 transmit and mode code give no pulse
        for (int k = 0; k < 2; k++) begin
            start_cmd(k == 1, k == 1);
            last_data = 1;
            tick();
            pulses_off();
            lows = (gbr_n == 0) ? 1 : 0;
            tick();
            lows += (gbr_n == 0) ? 1 : 0;
            chk("R5 no pulse for transmit or mode code", lows, 0);
            end_msg();
        end

        // R4 data error, R9 blocks pulse, R7 holds then clears
        start_cmd(1, 0);
        data_err = 1;
        tick();
        pulses_off();
        chk("R4 msg_err low after data error", msg_err_n, 0);
        last_data = 1;
        tick();
        pulses_off();
        chk("R9 no pulse after data error", gbr_n, 1);
        end_msg();
        tick(); tick();
        chk("R7 msg_err holds in idle", msg_err_n, 0);
        start_cmd(1, 0);
        chk("R7 msg_err cleared by command", msg_err_n, 1);
        data_err = 1; last_data = 1;
        tick();
        pulses_off();
        chk("R9 same-cycle error blocks pulse", gbr_n, 1);
        end_msg();

        // R3 command-word error
        start_cmd(1, 0);
        cmd_err = 1;
        tick();
        pulses_off();
        chk("R3 incmd high after cmd_err", incmd_n, 1);
        chk("R3 msg_err not set by cmd_err", msg_err_n, 1);
        data_err = 1; last_data = 1;
        tick();
        pulses_off();
        chk("R3 data error ignored", msg_err_n, 1);
        chk("R3 last data ignored", gbr_n, 1);
        cmd_valid = 1; cmd_err = 1; is_rx = 1;
        tick();
        pulses_off();
        chk("R3 cmd_err wins over cmd_valid", incmd_n, 1);

        // R8 capture cancelled by cmd_err
        start_cmd(0, 0);
        cmd_err = 1;
        tick();
        pulses_off();
        lows = 0;
        for (int i = 0; i < SMP + 2; i++) begin
            lows += stat_stb ? 1 : 0;
            tick();
        end
        chk("R8 cancelled capture", lows, 0);

        // R6 handshake timeout, R9, R7
        start_cmd(1, 0);
        dt_req = 1; dt_ack = 0;
        for (int i = 1; i < HS; i++) begin
            tick();
            if (i == HS - 1) chk("R6 no fail before limit", hs_fail_n, 1);
        end
        tick();
        chk("R6 fail at limit", hs_fail_n, 0);
        dt_req = 0;
        last_data = 1;
        tick();
        pulses_off();
        chk("R9 no pulse after handshake failure", gbr_n, 1);
        end_msg();
        chk("R7 hs_fail holds after eom", hs_fail_n, 0);
        start_cmd(1, 0);
        chk("R7 hs_fail cleared by command", hs_fail_n, 1);

        // R6 acknowledge restarts count
        dt_req = 1;
        for (int i = 1; i < HS; i++) tick();
        dt_ack = 1;
        tick();
        dt_ack = 0;
        for (int i = 1; i < HS; i++) tick();
        chk("R6 ack restarts timeout", hs_fail_n, 1);
        dt_req = 0;
        end_msg();

        // R10 request outside message
        dt_req = 1;
        for (int i = 0; i < 2 * HS; i++) tick();
        dt_req = 0;
        chk("R10 no fail outside message", hs_fail_n, 1);

        // random messages against the model
        for (int m = 0; m < 60; m++) begin
            logic rx, md;
            int nw, ea;
            rx = 1'($urandom % 2);
            md = (($urandom % 4) == 0);
            nw = 1 + int'($urandom % 4);
            ea = int'($urandom % 6);
            err = (ea < nw);
            start_cmd(rx, md);
            lows = 0;
            for (int w = 0; w < nw; w++) begin
                data_err  = (w == ea);
                last_data = (w == nw - 1);
                tick();
                pulses_off();
                lows += (gbr_n == 0) ? 1 : 0;
            end
            for (int t = 0; t < 3; t++) begin
                tick();
                lows += (gbr_n == 0) ? 1 : 0;
            end
            chk("R5 random good-block cycles", lows, want_gbr(rx, md, err) ? 2 : 0);
            end_msg();
            chk("R4 random error level", msg_err_n, !err);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule